// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 32-bit effective address into a 32-bit physical address in two steps. The top four address bits pick one of sixteen on-chip segment registers. Each register holds a 24-bit virtual segment identifier, and together with the 16-bit page index and the 12-bit byte offset it forms a 52-bit interim virtual address. A small two-way set-associative translation lookaside buffer then maps the virtual page (segment identifier plus page index) to a 20-bit physical page number. The byte offset passes through unchanged.

Software loads the segment registers through a register-write port. A lookup request is accepted whenever `req_ready` is high, and it resolves in the next cycle. It resolves either as a hit carrying the physical address or as a miss. On a miss, the block holds the request and shows the virtual page number it needs. It waits there until an external agent supplies the physical page number on the refill port. The refill is written into the least-recently-used way of the indexed set, and the held request then hits. A single-cycle invalidate input drops every cached translation. The page-table walk, protection checks and fault delivery are outside the block; the miss flag is the only fault indication.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `miss` are 0.
- R2: A write with `sr_wr_en` high stores `sr_wr_vsid` into segment register `sr_wr_idx`. A later request whose address bits [31:28] equal that index uses the stored identifier in its interim virtual address.
- R3: A request accepted at a clock edge (`req_valid` and `req_ready` both high) resolves in the cycle after that edge. Either `rsp_valid` is 1 or `miss` is 1, never both. On a hit, `rsp_pa` is {cached physical page, address bits [11:0]}.
- R4: On a miss, `miss_vpn` is {segment identifier, address bits [27:12]}. `req_ready` is 0 while `miss` is high. The miss and `miss_vpn` stay unchanged until a refill is written.
- R5: A `refill_en` pulse while `miss` is high writes `refill_ppn` for the held virtual page. In the next cycle `rsp_valid` is 1 and `rsp_pa` is {`refill_ppn`, offset}.
- R6: The set index is the low log2(TLB_SETS) bits of the page index. The tag is the segment identifier together with the remaining page-index bits. The same page index under a different segment identifier therefore misses.
- R7: Each set has two ways and one LRU bit. A hit marks the other way as the replacement candidate. A refill writes the candidate way and then marks the other way.
- R8: `inval_all` clears every valid bit in one cycle, so the next lookup misses. When `inval_all` and a refill arrive together, the invalidate wins: the refill is discarded and the miss stays held.
- R9: `refill_en` while no miss is held has no effect on the cached contents.
- R10: The segment identifier is sampled when the request is accepted. A segment-register write while a miss is held does not change `miss_vpn`, and the refill is tagged with the sampled identifier.
- R11: Address bits [11:0] appear untranslated in `rsp_pa[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Segment register write strobe |
| sr_wr_idx | input | 4 | Segment register number to write |
| sr_wr_vsid | input | 24 | Segment identifier to store |
| req_valid | input | 1 | Lookup request present |
| req_ea | input | 32 | Effective address to translate |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Translation hit, `rsp_pa` valid |
| rsp_pa | output | 32 | Physical address |
| miss | output | 1 | Held request missed, refill needed |
| miss_vpn | output | 40 | Virtual page of the held miss: {identifier, page index} |
| refill_en | input | 1 | Refill strobe |
| refill_ppn | input | 20 | Physical page number for the held miss |
| inval_all | input | 1 | Drop every cached translation |

## Verification
The bench builds the unit with TLB_SETS set to 4, so the cache holds only eight translations. With so few entries, a sweep over three segments and twelve page indices repeatedly fills each set, hits in it and evicts from it. A reference model with one LRU bit per set, computed arithmetically in the bench, predicts every hit, miss and physical address. The small set count also puts directed LRU eviction orders, identifier aliasing on the same page index, held-miss segment rewrites and invalidate-versus-refill collisions within a few dozen cycles each.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
  // Fixed associativity: one LRU bit per set covers exactly two ways.
  localparam int unsigned XL_WAYS = 2;
  typedef logic xl_way_t;
endpackage

// File: rtl/xlate_rst_sync.sv
`timescale 1ns/1ps
module xlate_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/seg_reg_bank.sv
`timescale 1ns/1ps
module seg_reg_bank #(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned VSID_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [VSID_W-1:0] wr_vsid,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [VSID_W-1:0] rd_vsid
);
  localparam int unsigned NREG = 1 << SEL_W;

  logic [VSID_W-1:0] sr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_sr
    logic ld;
    assign ld = wr_en && (wr_idx == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sr_q[g] <= '0;
      else if (ld) sr_q[g] <= wr_vsid;
    end
  end

  assign rd_vsid = sr_q[rd_idx];
endmodule

// File: rtl/xlate_req_stage.sv
`timescale 1ns/1ps
module xlate_req_stage #(
  parameter int unsigned LOW_W  = 28,
  parameter int unsigned VSID_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LOW_W-1:0]  req_low,
  input  logic [VSID_W-1:0] seg_vsid,
  input  logic              hit,
  output logic              req_ready,
  output logic              s_vld,
  output logic [LOW_W-1:0]  s_low,
  output logic [VSID_W-1:0] s_vsid
);
  logic              vld_d;
  logic [LOW_W-1:0]  low_d;
  logic [VSID_W-1:0] vsid_d;

  // The stage frees when empty or when its request hits.
  assign req_ready = !s_vld || hit;

  always_comb begin
    vld_d  = s_vld;
    low_d  = s_low;
    vsid_d = s_vsid;
    if (req_ready) begin
      vld_d = req_valid;
      if (req_valid) begin
        low_d  = req_low;
        vsid_d = seg_vsid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld  <= 1'b0;
      s_low  <= '0;
      s_vsid <= '0;
    end else begin
      s_vld  <= vld_d;
      s_low  <= low_d;
      s_vsid <= vsid_d;
    end
  end
endmodule

// File: rtl/xlate_tlb.sv
`timescale 1ns/1ps
module xlate_tlb
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SETS   = 32,
  parameter int unsigned VSID_W = 24,
  parameter int unsigned PIDX_W = 16,
  parameter int unsigned PPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VSID_W-1:0] lk_vsid,
  input  logic [PIDX_W-1:0] lk_pidx,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_en,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              inval_all
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VSID_W + PIDX_W - IDX_W;

  logic [SETS-1:0]  vld_q [XL_WAYS];
  logic [SETS-1:0]  vld_d [XL_WAYS];
  logic [SETS-1:0]  lru_q, lru_d;
  logic [TAG_W-1:0] tag_q [XL_WAYS][SETS];
  logic [PPN_W-1:0] ppn_q [XL_WAYS][SETS];

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [XL_WAYS-1:0] way_hit;
  xl_way_t            hit_way;
  xl_way_t            victim;
  logic               do_fill;
  logic               touch;

  assign idx = lk_pidx[IDX_W-1:0];
  assign tag = {lk_vsid, lk_pidx[PIDX_W-1:IDX_W]};

  for (genvar w = 0; w < XL_WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld_q[w][idx] && (tag_q[w][idx] == tag);
  end

  always_comb begin
    lk_ppn  = '0;
    hit_way = 1'b0;
    for (int w = 0; w < XL_WAYS; w++) begin
      if (way_hit[w]) begin
        lk_ppn  = lk_ppn | ppn_q[w][idx];
        hit_way = xl_way_t'(w);
      end
    end
  end

  assign lk_hit  = |way_hit;
  assign touch   = lk_valid && lk_hit;
  assign victim  = lru_q[idx];
  assign do_fill = fill_en && !inval_all;

  // Next state for valid bits and replacement bits.
  always_comb begin
    vld_d = vld_q;
    lru_d = lru_q;
    if (touch)   lru_d[idx] = ~hit_way;
    if (do_fill) lru_d[idx] = ~victim;
    if (inval_all) begin
      for (int w = 0; w < XL_WAYS; w++) vld_d[w] = '0;
    end else if (do_fill) begin
      vld_d[victim][idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < XL_WAYS; w++) vld_q[w] <= '0;
      lru_q <= '0;
    end else begin
      vld_q <= vld_d;
      lru_q <= lru_d;
    end
  end

  // Payload arrays carry no reset; valid bits guard them.
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[victim][idx] <= tag;
      ppn_q[victim][idx] <= fill_ppn;
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit #(
  parameter int unsigned EA_W      = 32,
  parameter int unsigned SEG_SEL_W = 4,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned VSID_W    = 24,
  parameter int unsigned PPN_W     = 20,
  parameter int unsigned TLB_SETS  = 32,
  localparam int unsigned PIDX_W   = EA_W - SEG_SEL_W - OFF_W,
  localparam int unsigned PA_W     = PPN_W + OFF_W,
  localparam int unsigned VPN_W    = VSID_W + PIDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sr_wr_en,
  input  logic [SEG_SEL_W-1:0] sr_wr_idx,
  input  logic [VSID_W-1:0]    sr_wr_vsid,
  input  logic                 req_valid,
  input  logic [EA_W-1:0]      req_ea,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 miss,
  output logic [VPN_W-1:0]     miss_vpn,
  input  logic                 refill_en,
  input  logic [PPN_W-1:0]     refill_ppn,
  input  logic                 inval_all
);
  localparam int unsigned LOW_W = PIDX_W + OFF_W;

  logic              rst_sync_n;
  logic [VSID_W-1:0] seg_vsid;
  logic              s_vld;
  logic [LOW_W-1:0]  s_low;
  logic [VSID_W-1:0] s_vsid;
  logic              tlb_hit;
  logic [PPN_W-1:0]  tlb_ppn;
  logic              fill_en;

  xlate_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  seg_reg_bank #(.SEL_W(SEG_SEL_W), .VSID_W(VSID_W)) u_segs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (sr_wr_en),
    .wr_idx  (sr_wr_idx),
    .wr_vsid (sr_wr_vsid),
    .rd_idx  (req_ea[EA_W-1 -: SEG_SEL_W]),
    .rd_vsid (seg_vsid)
  );

  xlate_req_stage #(.LOW_W(LOW_W), .VSID_W(VSID_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_low   (req_ea[LOW_W-1:0]),
    .seg_vsid  (seg_vsid),
    .hit       (tlb_hit),
    .req_ready (req_ready),
    .s_vld     (s_vld),
    .s_low     (s_low),
    .s_vsid    (s_vsid)
  );

  xlate_tlb #(
    .SETS(TLB_SETS), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .PPN_W(PPN_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lk_valid  (s_vld),
    .lk_vsid   (s_vsid),
    .lk_pidx   (s_low[LOW_W-1:OFF_W]),
    .lk_hit    (tlb_hit),
    .lk_ppn    (tlb_ppn),
    .fill_en   (fill_en),
    .fill_ppn  (refill_ppn),
    .inval_all (inval_all)
  );

  assign rsp_valid = s_vld && tlb_hit;
  assign miss      = s_vld && !tlb_hit;
  assign fill_en   = refill_en && miss;
  assign rsp_pa    = {tlb_ppn, s_low[OFF_W-1:0]};
  assign miss_vpn  = {s_vsid, s_low[LOW_W-1:OFF_W]};
endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned VPN_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             miss,
  input logic [VPN_W-1:0] miss_vpn,
  input logic             refill_en,
  input logic             inval_all
);
  // R3
  rsp_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && miss));

  // R3
  accept_resolves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || miss);

  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !req_ready);

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss && !refill_en |=> miss && $stable(miss_vpn));

  // R5
  refill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss && refill_en && !inval_all |=> rsp_valid);

  // R8
  inval_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all && req_valid && req_ready |=> miss);

  // R11
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid || (rsp_pa[OFF_W-1:0] == $past(req_off)));
endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .OFF_W(OFF_W), .PA_W(PA_W), .VPN_W(VPN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_off   (req_ea[OFF_W-1:0]),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_pa    (rsp_pa),
  .miss      (miss),
  .miss_vpn  (miss_vpn),
  .refill_en (refill_en),
  .inval_all (inval_all)
);

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;
  localparam int SETS = 4;
  localparam int IDXW = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sr_wr_en;
  logic [3:0]  sr_wr_idx;
  logic [23:0] sr_wr_vsid;
  logic        req_valid;
  logic [31:0] req_ea;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic        miss;
  logic [39:0] miss_vpn;
  logic        refill_en;
  logic [19:0] refill_ppn;
  logic        inval_all;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Reference model state
  logic [23:0] sr_m  [16];
  bit          m_vld [SETS][2];
  logic [37:0] m_tag [SETS][2];
  logic [19:0] m_ppn [SETS][2];
  bit          m_lru [SETS];

  always #4 clk = ~clk;

  seg_xlate_unit #(.TLB_SETS(SETS)) i_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .sr_wr_en(sr_wr_en), .sr_wr_idx(sr_wr_idx), .sr_wr_vsid(sr_wr_vsid),
    .req_valid(req_valid), .req_ea(req_ea), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .miss(miss), .miss_vpn(miss_vpn),
    .refill_en(refill_en), .refill_ppn(refill_ppn), .inval_all(inval_all)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish (cycles %0d, expected < 150000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ppn_of(input logic [23:0] v, input logic [15:0] p);
    return 20'(v * 3 + p * 17 + 20'h00101);
  endfunction

  function automatic int m_find(input int set, input logic [37:0] t);
    for (int w = 0; w < 2; w++)
      if (m_vld[set][w] && m_tag[set][w] == t) return w;
    return -1;
  endfunction

  task automatic m_fill(input int set, input logic [37:0] t, input logic [19:0] p);
    int v = int'(m_lru[set]);
    m_vld[set][v] = 1;
    m_tag[set][v] = t;
    m_ppn[set][v] = p;
    m_lru[set] = (v == 0);
  endtask

  task automatic m_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++) m_vld[s][w] = 0;
  endtask

  task automatic sr_write(input int idx, input logic [23:0] v);
    @(negedge clk);
    sr_wr_en = 1; sr_wr_idx = 4'(idx); sr_wr_vsid = v;
    @(negedge clk);
    sr_wr_en = 0;
    sr_m[idx] = v;
  endtask

  task automatic present(input logic [31:0] ea, input string req);
    @(negedge clk);
    chk(req_ready === 1'b1, req, "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1; req_ea = ea;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic refill(input logic [19:0] p);
    refill_en = 1; refill_ppn = p;
    @(negedge clk);
    refill_en = 0;
  endtask

  // Full lookup with model-predicted outcome; returns whether it hit.
  task automatic lookup(input logic [31:0] ea, input string req, output bit was_hit);
    logic [23:0] v = sr_m[ea[31:28]];
    logic [15:0] pi = ea[27:12];
    int set = int'(pi[IDXW-1:0]);
    logic [37:0] t = {v, pi[15:IDXW]};
    int w = m_find(set, t);
    logic [19:0] p;
    present(ea, req);
    if (w >= 0) begin
      was_hit = 1;
      chk(rsp_valid === 1'b1 && miss === 1'b0, req, "hit flags",
          64'({rsp_valid, miss}), 64'b10);
      chk(rsp_pa === {m_ppn[set][w], ea[11:0]}, {req, "/R3/R11"}, "hit address",
          64'(rsp_pa), 64'({m_ppn[set][w], ea[11:0]}));
      m_lru[set] = (w == 0);
    end else begin
      was_hit = 0;
      chk(miss === 1'b1 && rsp_valid === 1'b0, {req, "/R4"}, "miss flags",
          64'({rsp_valid, miss}), 64'b01);
      chk(miss_vpn === {v, pi}, {req, "/R2/R4"}, "miss page", 64'(miss_vpn), 64'({v, pi}));
      p = ppn_of(v, pi);
      refill(p);
      m_fill(set, t, p);
      chk(rsp_valid === 1'b1 && rsp_pa === {p, ea[11:0]}, {req, "/R5"}, "refilled address",
          64'(rsp_pa), 64'({p, ea[11:0]}));
    end
  endtask

  function automatic logic [31:0] mk_ea(input int seg, input int pi, input int off);
    return {4'(seg), 16'(pi), 12'(off)};
  endfunction

  initial begin
    bit h;
    logic [31:0] ea;
    logic [23:0] old_v;
    logic [19:0] p;
    rst_n = 0; sr_wr_en = 0; sr_wr_idx = '0; sr_wr_vsid = '0;
    req_valid = 0; req_ea = '0; refill_en = 0; refill_ppn = '0; inval_all = 0;
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) m_vld[s][w] = 0;
    end
    for (int i = 0; i < 16; i++) sr_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && miss === 1'b0, "R1", "reset outputs",
        64'({req_ready, rsp_valid, miss}), 64'b100);

    // R2: load all segment registers
    for (int i = 0; i < 16; i++) sr_write(i, 24'h0C0000 + 24'(i) * 24'h001111);

    // R7: directed eviction order in set 0 of segment 0
    lookup(mk_ea(0, 0, 12'h010), "R7", h); chk(!h, "R7", "A first", 64'(h), 0);
    lookup(mk_ea(0, 4, 12'h020), "R7", h); chk(!h, "R7", "B first", 64'(h), 0);
    lookup(mk_ea(0, 0, 12'h030), "R7", h); chk(h,  "R7", "A again", 64'(h), 1);
    lookup(mk_ea(0, 8, 12'h040), "R7", h); chk(!h, "R7", "C evicts B", 64'(h), 0);
    lookup(mk_ea(0, 0, 12'h050), "R7", h); chk(h,  "R7", "A kept", 64'(h), 1);
    lookup(mk_ea(0, 4, 12'h060), "R7", h); chk(!h, "R7", "B gone", 64'(h), 0);

    // R6: same page index, other segment identifier
    lookup(mk_ea(1, 0, 12'h070), "R6", h); chk(!h, "R6", "alias misses", 64'(h), 0);

    // R9: refill with nothing held
    @(negedge clk);
    refill_en = 1; refill_ppn = 20'hABCDE;
    @(negedge clk);
    refill_en = 0;
    chk(rsp_valid === 1'b0 && miss === 1'b0, "R9", "idle refill quiet",
        64'({rsp_valid, miss}), 0);
    lookup(mk_ea(2, 5, 12'h080), "R9", h); chk(!h, "R9", "no stray entry", 64'(h), 0);

    // R10: segment rewrite while miss held
    ea = mk_ea(3, 9, 12'h0F1);
    old_v = sr_m[3];
    present(ea, "R10");
    chk(miss === 1'b1, "R10", "miss held", 64'(miss), 1);
    sr_wr_en = 1; sr_wr_idx = 4'd3; sr_wr_vsid = 24'h7E7E7E;
    @(negedge clk);
    sr_wr_en = 0; sr_m[3] = 24'h7E7E7E;
    chk(miss === 1'b1 && miss_vpn === {old_v, 16'd9}, "R10", "held page unchanged",
        64'(miss_vpn), 64'({old_v, 16'd9}));
    p = ppn_of(old_v, 16'd9);
    refill(p);
    m_fill(1, {old_v, 14'd2}, p);
    chk(rsp_valid === 1'b1 && rsp_pa === {p, 12'h0F1}, "R10", "refill with sampled id",
        64'(rsp_pa), 64'({p, 12'h0F1}));
    lookup(ea, "R6", h); chk(!h, "R6", "new identifier misses", 64'(h), 0);

    // R8: invalidate collides with refill
    ea = mk_ea(4, 2, 12'h123);
    present(ea, "R8");
    inval_all = 1; refill_en = 1; refill_ppn = 20'h11111;
    @(negedge clk);
    inval_all = 0; refill_en = 0;
    m_clear();
    chk(miss === 1'b1 && rsp_valid === 1'b0, "R8", "invalidate beats refill",
        64'({rsp_valid, miss}), 64'b01);
    p = ppn_of(sr_m[4], 16'd2);
    refill(p);
    m_fill(2, {sr_m[4], 14'd0}, p);
    chk(rsp_valid === 1'b1 && rsp_pa === {p, 12'h123}, "R8", "later refill lands",
        64'(rsp_pa), 64'({p, 12'h123}));
    lookup(ea, "R8", h); chk(h, "R8", "entry present", 64'(h), 1);
    @(negedge clk);
    inval_all = 1;
    @(negedge clk);
    inval_all = 0;
    m_clear();
    lookup(ea, "R8", h); chk(!h, "R8", "cleared by invalidate", 64'(h), 0);

    // R3: sweep over three segments and twelve pages
    for (int n = 0; n < 400; n++) begin
      lookup(mk_ea(n % 3, (n * 5 + n / 7) % 12, (n * 397) % 4096), "R3", h);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule